// File: doc/BRIEF.md
# Video Memory Data Port Controller

This block serves the data port of a video controller. A host reads or writes one 16-bit word at a time. Each access goes to one of three internal memories: a word-wide video RAM, a small vertical-scroll RAM holding 10-bit entries, and a colour RAM holding 9-bit entries. A command register supplies a 4-bit access code and a 16-bit access address. The code selects the memory and the direction of the access. The address selects the entry and then advances by a programmable 8-bit step after every access that succeeds.

Each memory has its own packing. Video RAM stores whole words, but a write to an odd address stores the two bytes swapped. Vertical-scroll RAM keeps only the low ten data bits. Colour RAM keeps three 3-bit fields taken from spaced-out bit positions and spreads them back to the same positions on a read. Every data-port access, whatever its code, sends a one-cycle pulse that the control-port logic uses to drop its half-written-command flag. A fill-wait flag, armed by a DMA fill engine, is released by the next data write. That write also latches the upper data byte as the fill value and still performs its normal memory write.

Top module: `vram_port_ctrl`

## Requirements
- R1: After reset `acc_addr` is 0x0000, `dp_rvalid`, `pend_clr` and `fill_wait` are 0, and `fill_value` is 0x00.
- R2: Access codes: 0 reads video RAM, 4 reads scroll RAM, 8 reads colour RAM, 1 writes video RAM, 5 writes scroll RAM, 3 writes colour RAM. A read with any other code returns 0x0000 with `dp_rvalid` set. A write with any other code changes no memory. Neither of these advances the address.
- R3: After every successful read or write, `acc_addr` becomes `acc_addr + inc_step`, modulo 2^16. A `cmd_load` replaces the code and the address.
- R4: The video RAM word index is `acc_addr[VRAM_AW:1]`, and higher address bits alias. A write with `acc_addr[0]` = 1 stores `{wdata[7:0], wdata[15:8]}`. An even write stores the word unchanged. A read returns the stored word.
- R5: The scroll RAM index is `acc_addr[6:1]`. A write stores `wdata[9:0]`. A read returns the value with bits 15..10 at zero. An index of `VS_DEPTH` or more discards the write, and a read of such an index returns zero.
- R6: A colour write stores `{wdata[11:9], wdata[7:5], wdata[3:1]}` at index `acc_addr[6:1]`. A colour read returns those fields at bits 11..9, 7..5 and 3..1, with every other bit zero.
- R7: A read presents `dp_rdata` with `dp_rvalid` high for exactly the cycle after the request.
- R8: `pend_clr` is high for one cycle after any data-port read or write, whatever the code.
- R9: A `fill_arm` pulse sets `fill_wait`. A data write while `fill_wait` is set clears it, loads `fill_value` with `wdata[15:8]`, and still performs the memory write. A write while the flag is clear leaves `fill_value` unchanged.
- R10: If `dp_rd` and `dp_wr` are high together, only the write is performed and `dp_rvalid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Load access code and address |
| cmd_code | input | 4 | Access code to load |
| cmd_addr | input | 16 | Access address to load |
| inc_step | input | 8 | Address advance per access |
| dp_rd | input | 1 | Data-port read request |
| dp_wr | input | 1 | Data-port write request |
| dp_wdata | input | 16 | Data-port write word |
| dp_rdata | output | 16 | Read word, valid with dp_rvalid |
| dp_rvalid | output | 1 | Read result strobe |
| pend_clr | output | 1 | Command-pending clear pulse |
| fill_arm | input | 1 | DMA fill engine requests a fill value |
| fill_wait | output | 1 | Fill value awaited |
| fill_value | output | 8 | Latched fill byte |
| acc_addr | output | 16 | Current access address |

## Verification
The bench builds the block with `VRAM_AW` = 8, `VS_DEPTH` = 40 and `CRAM_DEPTH` = 64. The small video RAM makes aliasing of address bits above bit 8 observable within a few accesses. The scroll depth of 40 leaves indices 40 to 63 reachable, so the discarded write and the zero read can be checked. A start address of 0xFFFF with a step of 3 exercises the 16-bit wrap.

// File: rtl/vport_pkg.sv
package vport_pkg;

    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 16;
    localparam int INC_W       = 8;
    localparam int CODE_W      = 4;
    localparam int VS_W        = 10;
    localparam int CRAM_W      = 9;
    localparam int SMALL_IDX_W = 6;

    localparam logic [CODE_W-1:0] CODE_VRAM_RD = 4'd0;
    localparam logic [CODE_W-1:0] CODE_VRAM_WR = 4'd1;
    localparam logic [CODE_W-1:0] CODE_CRAM_WR = 4'd3;
    localparam logic [CODE_W-1:0] CODE_VS_RD   = 4'd4;
    localparam logic [CODE_W-1:0] CODE_VS_WR   = 4'd5;
    localparam logic [CODE_W-1:0] CODE_CRAM_RD = 4'd8;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_VRAM = 2'd1,
        TGT_VS   = 2'd2,
        TGT_CRAM = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic is_wr;
    } decode_t;

    function automatic decode_t decode_code(input logic [CODE_W-1:0] c);
        decode_t d;
        d.tgt   = TGT_NONE;
        d.is_wr = 1'b0;
        case (c)
            CODE_VRAM_RD: d.tgt = TGT_VRAM;
            CODE_VS_RD:   d.tgt = TGT_VS;
            CODE_CRAM_RD: d.tgt = TGT_CRAM;
            CODE_VRAM_WR: begin d.tgt = TGT_VRAM; d.is_wr = 1'b1; end
            CODE_VS_WR:   begin d.tgt = TGT_VS;   d.is_wr = 1'b1; end
            CODE_CRAM_WR: begin d.tgt = TGT_CRAM; d.is_wr = 1'b1; end
            default: ;
        endcase
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] w);
        return {w[7:0], w[15:8]};
    endfunction

    function automatic logic [CRAM_W-1:0] cram_pack(input logic [DATA_W-1:0] w);
        return {w[11:9], w[7:5], w[3:1]};
    endfunction

    function automatic logic [DATA_W-1:0] cram_unpack(input logic [CRAM_W-1:0] q);
        logic [DATA_W-1:0] r;
        r        = '0;
        r[3:1]   = q[2:0];
        r[7:5]   = q[5:3];
        r[11:9]  = q[8:6];
        return r;
    endfunction

endpackage

// File: rtl/vport_cmd_reg.sv
module vport_cmd_reg
    import vport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] load_code,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    input  logic [INC_W-1:0]  inc,
    output logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] next_addr;
    assign next_addr = addr + ADDR_W'(inc);

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
            addr <= '0;
        end else if (load) begin
            code <= load_code;
            addr <= load_addr;
        end else if (step) begin
            addr <= next_addr;
        end
    end

endmodule

// File: rtl/vport_bank.sv
module vport_bank #(
    parameter int W     = 16,
    parameter int AW    = 6,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  q
);

    localparam int SLOTS = 1 << AW;

    logic [W-1:0] mem [SLOTS];
    logic         in_range;

    generate
        if (DEPTH < SLOTS) begin : g_partial
            assign in_range = (idx < AW'(DEPTH));
        end else begin : g_full
            assign in_range = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (we && in_range) begin
            mem[idx] <= wdata;
        end
        if (re) begin
            q <= in_range ? mem[idx] : '0;
        end
    end

endmodule

// File: rtl/vport_fill.sv
module vport_fill (
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic       data_wr,
    input  logic [7:0] upper,
    output logic       waiting,
    output logic [7:0] value
);

    always_ff @(posedge clk) begin
        if (rst) begin
            waiting <= 1'b0;
            value   <= '0;
        end else begin
            if (data_wr && waiting) begin
                waiting <= 1'b0;
                value   <= upper;
            end
            if (arm) begin
                waiting <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/vram_port_ctrl.sv
module vram_port_ctrl
    import vport_pkg::*;
#(
    parameter int VRAM_AW    = 10,
    parameter int VS_DEPTH   = 40,
    parameter int CRAM_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_load,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [INC_W-1:0]  inc_step,
    input  logic              dp_rd,
    input  logic              dp_wr,
    input  logic [DATA_W-1:0] dp_wdata,
    output logic [DATA_W-1:0] dp_rdata,
    output logic              dp_rvalid,
    output logic              pend_clr,
    input  logic              fill_arm,
    output logic              fill_wait,
    output logic [7:0]        fill_value,
    output logic [ADDR_W-1:0] acc_addr
);

    localparam int VRAM_DEPTH = 1 << VRAM_AW;

    logic [CODE_W-1:0]      code_q;
    logic [ADDR_W-1:0]      addr_q;
    decode_t                dec;
    logic                   hit;
    logic                   rd_only;
    logic                   wr_go;
    logic                   rd_go;
    logic [VRAM_AW-1:0]     vram_idx;
    logic [SMALL_IDX_W-1:0] small_idx;
    logic [DATA_W-1:0]      vram_wdata;
    logic [DATA_W-1:0]      vram_q;
    logic [VS_W-1:0]        vs_q;
    logic [CRAM_W-1:0]      cram_q;
    tgt_e                   rd_tgt_q;
    logic                   rvalid_q;
    logic                   pend_q;

    assign dec     = decode_code(code_q);
    assign hit     = (dec.tgt != TGT_NONE);
    assign rd_only = dp_rd && !dp_wr;
    assign wr_go   = dp_wr && hit && dec.is_wr;
    assign rd_go   = rd_only && hit && !dec.is_wr;

    vport_cmd_reg u_cmd (
        .clk       (clk),
        .rst       (rst),
        .load      (cmd_load),
        .load_code (cmd_code),
        .load_addr (cmd_addr),
        .step      (wr_go || rd_go),
        .inc       (inc_step),
        .code      (code_q),
        .addr      (addr_q)
    );

    assign vram_idx   = addr_q[VRAM_AW:1];
    assign small_idx  = addr_q[SMALL_IDX_W:1];
    assign vram_wdata = addr_q[0] ? swap_bytes(dp_wdata) : dp_wdata;

    vport_bank #(.W(DATA_W), .AW(VRAM_AW), .DEPTH(VRAM_DEPTH)) u_vram (
        .clk   (clk),
        .we    (wr_go && dec.tgt == TGT_VRAM),
        .re    (rd_go && dec.tgt == TGT_VRAM),
        .idx   (vram_idx),
        .wdata (vram_wdata),
        .q     (vram_q)
    );

    vport_bank #(.W(VS_W), .AW(SMALL_IDX_W), .DEPTH(VS_DEPTH)) u_vs (
        .clk   (clk),
        .we    (wr_go && dec.tgt == TGT_VS),
        .re    (rd_go && dec.tgt == TGT_VS),
        .idx   (small_idx),
        .wdata (dp_wdata[VS_W-1:0]),
        .q     (vs_q)
    );

    vport_bank #(.W(CRAM_W), .AW(SMALL_IDX_W), .DEPTH(CRAM_DEPTH)) u_cram (
        .clk   (clk),
        .we    (wr_go && dec.tgt == TGT_CRAM),
        .re    (rd_go && dec.tgt == TGT_CRAM),
        .idx   (small_idx),
        .wdata (cram_pack(dp_wdata)),
        .q     (cram_q)
    );

    vport_fill u_fill (
        .clk     (clk),
        .rst     (rst),
        .arm     (fill_arm),
        .data_wr (dp_wr),
        .upper   (dp_wdata[15:8]),
        .waiting (fill_wait),
        .value   (fill_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_tgt_q <= TGT_NONE;
            rvalid_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            rvalid_q <= rd_only;
            pend_q   <= dp_rd || dp_wr;
            if (rd_only) begin
                rd_tgt_q <= rd_go ? dec.tgt : TGT_NONE;
            end
        end
    end

    always_comb begin
        case (rd_tgt_q)
            TGT_VRAM: dp_rdata = vram_q;
            TGT_VS:   dp_rdata = {{(DATA_W-VS_W){1'b0}}, vs_q};
            TGT_CRAM: dp_rdata = cram_unpack(cram_q);
            default:  dp_rdata = '0;
        endcase
    end

    assign dp_rvalid = rvalid_q;
    assign pend_clr  = pend_q;
    assign acc_addr  = addr_q;

endmodule

// File: rtl/vram_port_ctrl_chk.sv
module vram_port_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_load,
    input logic [3:0]  cur_code,
    input logic [7:0]  inc_step,
    input logic        dp_rd,
    input logic        dp_wr,
    input logic [15:0] dp_wdata,
    input logic [15:0] dp_rdata,
    input logic        dp_rvalid,
    input logic        pend_clr,
    input logic        fill_arm,
    input logic        fill_wait,
    input logic [7:0]  fill_value,
    input logic [15:0] acc_addr
);

    assert_rvalid_timing_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (dp_rvalid == $past(dp_rd && !dp_wr)));

    assert_pend_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pend_clr == $past(dp_rd || dp_wr)));

    assert_both_no_read_R10: assert property (@(posedge clk) disable iff (rst)
        (dp_rd && dp_wr) |=> !dp_rvalid);

    assert_fill_release_R9: assert property (@(posedge clk) disable iff (rst)
        (dp_wr && fill_wait && !fill_arm) |=>
            (!fill_wait && fill_value == $past(dp_wdata[15:8])));

    assert_write_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!cmd_load && dp_wr && (cur_code == 4'd1 || cur_code == 4'd3 || cur_code == 4'd5))
            |=> (acc_addr == $past(acc_addr) + {8'h00, $past(inc_step)}));

    assert_bad_code_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!cmd_load && dp_wr && !(cur_code == 4'd1 || cur_code == 4'd3 || cur_code == 4'd5))
            |=> $stable(acc_addr));

    assert_bad_read_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (dp_rd && !dp_wr && !(cur_code == 4'd0 || cur_code == 4'd4 || cur_code == 4'd8))
            |=> (dp_rdata == 16'h0000));

    assert_vs_width_R5: assert property (@(posedge clk) disable iff (rst)
        (dp_rd && !dp_wr && cur_code == 4'd4) |=> (dp_rdata[15:10] == 6'h00));

    assert_cram_spread_R6: assert property (@(posedge clk) disable iff (rst)
        (dp_rd && !dp_wr && cur_code == 4'd8) |=> ((dp_rdata & 16'hF111) == 16'h0000));

endmodule

bind vram_port_ctrl vram_port_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_load   (cmd_load),
    .cur_code   (code_q),
    .inc_step   (inc_step),
    .dp_rd      (dp_rd),
    .dp_wr      (dp_wr),
    .dp_wdata   (dp_wdata),
    .dp_rdata   (dp_rdata),
    .dp_rvalid  (dp_rvalid),
    .pend_clr   (pend_clr),
    .fill_arm   (fill_arm),
    .fill_wait  (fill_wait),
    .fill_value (fill_value),
    .acc_addr   (acc_addr)
);

// File: tb/vram_port_ctrl_tb.sv
`timescale 1ns/1ps
module vram_port_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_load = 1'b0;
    logic [3:0]  cmd_code = '0;
    logic [15:0] cmd_addr = '0;
    logic [7:0]  inc_step = 8'd2;
    logic        dp_rd = 1'b0;
    logic        dp_wr = 1'b0;
    logic [15:0] dp_wdata = '0;
    logic [15:0] dp_rdata;
    logic        dp_rvalid;
    logic        pend_clr;
    logic        fill_arm = 1'b0;
    logic        fill_wait;
    logic [7:0]  fill_value;
    logic [15:0] acc_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [15:0] rd_word;
    logic        rd_valid;
    logic        rd_pend;

    always #4 clk = ~clk;

    vram_port_ctrl #(.VRAM_AW(8), .VS_DEPTH(40), .CRAM_DEPTH(64)) u_dut (
        .clk(clk), .rst(rst), .cmd_load(cmd_load), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .inc_step(inc_step), .dp_rd(dp_rd), .dp_wr(dp_wr),
        .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .dp_rvalid(dp_rvalid),
        .pend_clr(pend_clr), .fill_arm(fill_arm), .fill_wait(fill_wait),
        .fill_value(fill_value), .acc_addr(acc_addr)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic load_cmd(input logic [3:0] c, input logic [15:0] a);
        @(negedge clk);
        cmd_load = 1'b1; cmd_code = c; cmd_addr = a;
        @(negedge clk);
        cmd_load = 1'b0;
    endtask

    task automatic put(input logic [15:0] d);
        @(negedge clk);
        dp_wr = 1'b1; dp_wdata = d;
        @(negedge clk);
        dp_wr = 1'b0;
    endtask

    task automatic get();
        @(negedge clk);
        dp_rd = 1'b1;
        @(negedge clk);
        dp_rd = 1'b0;
        rd_word  = dp_rdata;
        rd_valid = dp_rvalid;
        rd_pend  = pend_clr;
    endtask

    task automatic t_reset();
        check("R1 acc_addr", acc_addr, 16'h0000);
        check("R1 rvalid", {15'd0, dp_rvalid}, 16'h0);
        check("R1 pend_clr", {15'd0, pend_clr}, 16'h0);
        check("R1 fill_wait", {15'd0, fill_wait}, 16'h0);
        check("R1 fill_value", {8'd0, fill_value}, 16'h0);
    endtask

    task automatic t_vram();
        inc_step = 8'd2;
        load_cmd(4'd1, 16'h0010);
        put(16'h1234);
        put(16'hABCD);
        check("R3 addr after two writes", acc_addr, 16'h0014);
        load_cmd(4'd0, 16'h0010);
        get();
        check("R4 vram even read 0", rd_word, 16'h1234);
        check("R7 rvalid after read", {15'd0, rd_valid}, 16'h1);
        check("R8 pend_clr after read", {15'd0, rd_pend}, 16'h1);
        get();
        check("R4 vram even read 1", rd_word, 16'hABCD);
        check("R3 addr after two reads", acc_addr, 16'h0014);
        @(negedge clk);
        check("R7 rvalid drops", {15'd0, dp_rvalid}, 16'h0);
        check("R8 pend_clr drops", {15'd0, pend_clr}, 16'h0);
    endtask

    task automatic t_swap();
        load_cmd(4'd1, 16'h0021);
        put(16'h5678);
        load_cmd(4'd0, 16'h0020);
        get();
        check("R4 odd write swaps bytes", rd_word, 16'h7856);
        load_cmd(4'd0, 16'h0220);
        get();
        check("R4 upper address bits alias", rd_word, 16'h7856);
    endtask

    task automatic t_vs();
        load_cmd(4'd5, 16'h0002);
        put(16'hFFFF);
        load_cmd(4'd4, 16'h0002);
        get();
        check("R5 scroll keeps low 10 bits", rd_word, 16'h03FF);
        load_cmd(4'd4, 16'h0082);
        get();
        check("R5 scroll index from bits 6..1", rd_word, 16'h03FF);
        load_cmd(4'd5, 16'h0050);
        put(16'h0123);
        load_cmd(4'd4, 16'h0050);
        get();
        check("R5 index beyond depth reads zero", rd_word, 16'h0000);
    endtask

    task automatic t_cram();
        load_cmd(4'd3, 16'h0004);
        put(16'hFFFF);
        load_cmd(4'd8, 16'h0004);
        get();
        check("R6 colour all ones", rd_word, 16'h0EEE);
        load_cmd(4'd3, 16'h0006);
        put(16'h0A5C);
        load_cmd(4'd8, 16'h0006);
        get();
        check("R6 colour field packing", rd_word, 16'h0A4C);
    endtask

    task automatic t_bad_code();
        load_cmd(4'd2, 16'h0100);
        put(16'h9999);
        check("R2 bad write holds address", acc_addr, 16'h0100);
        get();
        check("R2 bad read returns zero", rd_word, 16'h0000);
        check("R2 bad read still valid", {15'd0, rd_valid}, 16'h1);
        check("R8 pend_clr on bad code", {15'd0, rd_pend}, 16'h1);
        check("R2 bad read holds address", acc_addr, 16'h0100);
        load_cmd(4'd1, 16'h0030);
        get();
        check("R2 read with write code is zero", rd_word, 16'h0000);
        check("R2 read with write code holds address", acc_addr, 16'h0030);
        load_cmd(4'd0, 16'h0010);
        get();
        check("R2 no memory change by bad write", rd_word, 16'h1234);
    endtask

    task automatic t_wrap();
        inc_step = 8'd3;
        load_cmd(4'd1, 16'hFFFF);
        put(16'h0000);
        check("R3 address wraps modulo 2^16", acc_addr, 16'h0002);
        inc_step = 8'd2;
    endtask

    task automatic t_fill();
        @(negedge clk);
        fill_arm = 1'b1;
        @(negedge clk);
        fill_arm = 1'b0;
        check("R9 fill_wait set", {15'd0, fill_wait}, 16'h1);
        load_cmd(4'd1, 16'h0040);
        put(16'hC3A5);
        check("R9 fill_wait released", {15'd0, fill_wait}, 16'h0);
        check("R9 fill_value latched", {8'd0, fill_value}, 16'h00C3);
        put(16'h1100);
        check("R9 fill_value kept when not waiting", {8'd0, fill_value}, 16'h00C3);
        load_cmd(4'd0, 16'h0040);
        get();
        check("R9 fill write still stored", rd_word, 16'hC3A5);
    endtask

    task automatic t_both();
        load_cmd(4'd1, 16'h0060);
        @(negedge clk);
        dp_rd = 1'b1; dp_wr = 1'b1; dp_wdata = 16'h2222;
        @(negedge clk);
        dp_rd = 1'b0; dp_wr = 1'b0;
        check("R10 no rvalid on combined access", {15'd0, dp_rvalid}, 16'h0);
        check("R10 write advanced address", acc_addr, 16'h0062);
        load_cmd(4'd0, 16'h0060);
        get();
        check("R10 write performed", rd_word, 16'h2222);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_vram();
        t_swap();
        t_vs();
        t_cram();
        t_bad_code();
        t_wrap();
        t_fill();
        t_both();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule